// File: doc/BRIEF.md
# Drive-Bay LED Serial Shifter

This block holds three LED bits per disk port (activity, locate and fault) and sends the whole pattern to an external drive-bay LED controller. The link has three wires: a clock, a load strobe and a data line. A requester offers a port number and a 32-bit LED message. The block decodes three LED states from scattered bits of the message. It writes them into the pattern at a bit position that a configurable port-to-slot map picks. It then plays out one frame.

A frame is a list of clock slots in this order:
- a configurable number of idle leading slots;
- one slot with load high;
- one slot per pattern bit, least significant bit first;
- a configurable number of idle trailing slots.

Each slot has a low half-period and then a high half-period, each `HALF_CYC` clock cycles long. The values for a slot are presented at the start of its low half, so load and data only change while the link clock is low. A final low half-period closes the frame, holding the last values. After it all three lines return high.

Requests use a valid/ready pair, and ready is high only while the block is idle. A request that arrives during a frame therefore waits until the frame ends. A message whose slot field (bits 15:8) is at or above `MSG_SLOTS` is refused. The block then raises an error pulse and sends no frame.

States and transitions of the frame controller:
- ST_IDLE → ST_PRE on an accepted request when the leading count is non-zero, otherwise ST_IDLE → ST_LOAD.
- ST_PRE → ST_LOAD after the last leading slot.
- ST_LOAD → ST_SHIFT after the single load slot.
- ST_SHIFT → ST_POST after the last pattern bit when the trailing count is non-zero, otherwise ST_SHIFT → ST_TAIL.
- ST_POST → ST_TAIL after the last trailing slot.
- ST_TAIL → ST_IDLE after one low half-period.

Within every state except ST_IDLE and ST_TAIL, a phase bit steps from low to high. A slot ends when the high half finishes.

Top module: `sgpio_led_shifter`

## Requirements
- R1: A message accepted for port p writes pattern bits 3*s, 3*s+1 and 3*s+2, where s is the 3-bit field at bits [3p+2:3p] of `cfg_slot_map`. It changes no other pattern bit.
- R2: The activity bit (3*s) becomes 1 when message bit 20 or bit 21 is 1, and becomes 0 when both are 0.
- R3: The locate bit (3*s+1) copies message bit 19 and the fault bit (3*s+2) copies message bit 22, so either bit is cleared by a message with that bit at 0.
- R4: The slots of a frame come in this order:
  - `cfg_pre` slots with load 0 and data 1;
  - exactly one slot with load 1 and data 1;
  - 3*`cfg_nports` slots with load 0 carrying pattern bits 0 upward;
  - `cfg_post` slots with load 0 and data 1.
- R5: Each slot drives `sg_clk` low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. The slot's load and data values appear at the start of its low half. One more low half-period that keeps the last slot's values ends the frame. Load and data never change while `sg_clk` is high during a frame.
- R6: A leading or trailing count of 0 produces no slot of that kind.
- R7: A request whose message bits 15:8 are greater than or equal to `MSG_SLOTS` raises `req_err` for one cycle in the next cycle. It leaves the pattern unchanged and starts no frame. A value of `MSG_SLOTS`-1 is accepted.
- R8: `req_ready` is high only when no frame is in progress. A request held while it is low is taken in the first idle cycle and is sent in a frame after the current one.
- R9: After reset `sg_clk`, `sg_load` and `sg_data` are high, `req_ready` is high, `req_err` is low and the pattern is all zero.
- R10: Message bits other than 8 to 15 and 19 to 22 have no effect on the pattern or the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Update request offered |
| req_port | input | PORT_W (3) | Port the message belongs to |
| req_msg | input | 32 | LED message |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_err | output | 1 | One-cycle pulse for a refused message |
| cfg_pre | input | CLKCNT_W (8) | Number of leading idle slots |
| cfg_post | input | CLKCNT_W (8) | Number of trailing idle slots |
| cfg_nports | input | PORT_W+1 (4) | Ports sent per frame, 1 to N_PORTS |
| cfg_slot_map | input | N_PORTS*SLOT_W (24) | Slot number for each port, 3 bits per port |
| sg_clk | output | 1 | Link clock, idles high |
| sg_load | output | 1 | Load strobe, idles high |
| sg_data | output | 1 | Serial data, idles high |

## Verification
The hardest situation to reach is a second request arriving while a frame is on the wire. That request has to wait a full frame and must then show both updates in its own frame. The bench issues a request right after an accepted one and holds valid through the busy period. The reference model, which only accepts in its own idle cycles, predicts the exact cycle of the second frame. A refused message at the slot-field boundary, and zero and non-zero leading and trailing counts, are reached by reprogramming the configuration between frames.

// File: rtl/sgpio_led_pkg.sv
package sgpio_led_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_LOAD,
        ST_SHIFT,
        ST_POST,
        ST_TAIL
    } frame_st_e;

    // {fault, locate, activity} from an LED message
    function automatic logic [2:0] led_decode(input logic [31:0] msg);
        return {msg[22], msg[19], msg[20] | msg[21]};
    endfunction

endpackage

// File: rtl/sgpio_led_pattern.sv
module sgpio_led_pattern #(
    parameter int N_PORTS = 8,
    parameter int SLOT_W  = 3,
    parameter int PORT_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PORT_W-1:0]           wr_port,
    input  logic [2:0]                  wr_bits,
    input  logic [N_PORTS*SLOT_W-1:0]   slot_map,
    output logic [3*N_PORTS-1:0]        pattern
);

    logic [SLOT_W-1:0] wr_slot;
    logic [2:0]        slot_q [N_PORTS];

    assign wr_slot = slot_map[wr_port*SLOT_W +: SLOT_W];

    for (genvar s = 0; s < N_PORTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                slot_q[s] <= wr_bits;
            end
        end
        assign pattern[3*s +: 3] = slot_q[s];
    end

endmodule

// File: rtl/sgpio_half_timer.sv
module sgpio_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_done
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign half_done = run && (cnt == CW'(HALF_CYC - 1));

endmodule

// File: rtl/sgpio_led_shifter.sv
module sgpio_led_shifter
    import sgpio_led_pkg::*;
#(
    parameter int N_PORTS    = 8,
    parameter int HALF_CYC   = 4,
    parameter int MSG_SLOTS  = 15,
    parameter int CLKCNT_W   = 8,
    localparam int PORT_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int SLOT_W    = PORT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [PORT_W-1:0]           req_port,
    input  logic [31:0]                 req_msg,
    output logic                        req_ready,
    output logic                        req_err,
    input  logic [CLKCNT_W-1:0]         cfg_pre,
    input  logic [CLKCNT_W-1:0]         cfg_post,
    input  logic [PORT_W:0]             cfg_nports,
    input  logic [N_PORTS*SLOT_W-1:0]   cfg_slot_map,
    output logic                        sg_clk,
    output logic                        sg_load,
    output logic                        sg_data
);

    localparam int PB    = 3 * N_PORTS;
    localparam int IDX_W = $clog2(PB + 1);
    localparam int IW    = (CLKCNT_W > IDX_W) ? CLKCNT_W : IDX_W;

    frame_st_e          st, st_nx;
    logic               ph, ph_nx;
    logic [IW-1:0]      idx, idx_nx;
    logic               half_done;
    logic               bad_slot, accept, err_q;
    logic [PB-1:0]      pattern;
    logic [IW-1:0]      pre_last, post_last, bits_last;
    logic               shift_bit, tail_bit;

    assign bad_slot  = req_msg[15:8] >= 8'(MSG_SLOTS);
    assign accept    = (st == ST_IDLE) && req_valid && !bad_slot;
    assign req_ready = (st == ST_IDLE);
    assign req_err   = err_q;

    assign pre_last  = IW'(cfg_pre) - IW'(1);
    assign post_last = IW'(cfg_post) - IW'(1);
    assign bits_last = IW'(3 * int'(cfg_nports)) - IW'(1);

    sgpio_led_pattern #(
        .N_PORTS (N_PORTS),
        .SLOT_W  (SLOT_W),
        .PORT_W  (PORT_W)
    ) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_port  (req_port),
        .wr_bits  (led_decode(req_msg)),
        .slot_map (cfg_slot_map),
        .pattern  (pattern)
    );

    sgpio_half_timer #(
        .HALF_CYC (HALF_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st != ST_IDLE),
        .half_done (half_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ph    <= 1'b0;
            idx   <= '0;
            err_q <= 1'b0;
        end else begin
            st    <= st_nx;
            ph    <= ph_nx;
            idx   <= idx_nx;
            err_q <= (st == ST_IDLE) && req_valid && bad_slot;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx  = st;
        ph_nx  = ph;
        idx_nx = idx;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    st_nx  = (cfg_pre == '0) ? ST_LOAD : ST_PRE;
                    ph_nx  = 1'b0;
                    idx_nx = '0;
                end
            end
            ST_TAIL: begin
                if (half_done) st_nx = ST_IDLE;
            end
            default: begin
                if (half_done) begin
                    if (!ph) begin
                        ph_nx = 1'b1;
                    end else begin
                        ph_nx  = 1'b0;
                        idx_nx = idx + IW'(1);
                        case (st)
                            ST_PRE: begin
                                if (idx == pre_last) begin
                                    st_nx  = ST_LOAD;
                                    idx_nx = '0;
                                end
                            end
                            ST_LOAD: begin
                                st_nx  = ST_SHIFT;
                                idx_nx = '0;
                            end
                            ST_SHIFT: begin
                                if (idx == bits_last) begin
                                    st_nx  = (cfg_post == '0) ? ST_TAIL : ST_POST;
                                    idx_nx = '0;
                                end
                            end
                            ST_POST: begin
                                if (idx == post_last) st_nx = ST_TAIL;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end

    assign shift_bit = (idx < IW'(PB)) ? pattern[idx[IDX_W-1:0]] : 1'b0;
    assign tail_bit  = (cfg_post != '0) ? 1'b1
                     : ((bits_last < IW'(PB)) ? pattern[bits_last[IDX_W-1:0]] : 1'b0);

    // Output logic
    always_comb begin
        sg_clk  = 1'b1;
        sg_load = 1'b1;
        sg_data = 1'b1;
        unique case (st)
            ST_IDLE: ;
            ST_PRE, ST_POST: begin
                sg_clk  = ph;
                sg_load = 1'b0;
            end
            ST_LOAD: begin
                sg_clk  = ph;
            end
            ST_SHIFT: begin
                sg_clk  = ph;
                sg_load = 1'b0;
                sg_data = shift_bit;
            end
            ST_TAIL: begin
                sg_clk  = 1'b0;
                sg_load = 1'b0;
                sg_data = tail_bit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sgpio_led_checker.sv
module sgpio_led_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_err,
    input logic sg_clk,
    input logic sg_load,
    input logic sg_data
);

    // R9: while idle all three link lines sit high
    a_r9_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sg_clk && sg_load && sg_data));

    // R5: inside a frame, load and data move only with the link clock low
    a_r5_edges_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && (!$stable(sg_data) || !$stable(sg_load))) |-> !sg_clk);

    // R7: a refused message leaves the block idle
    a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ready);

    // R8: a frame begins only on an offered request, with the clock low
    a_r8_start_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> ($past(req_valid) && !sg_clk));

endmodule

bind sgpio_led_shifter sgpio_led_checker u_sgpio_led_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_err   (req_err),
    .sg_clk    (sg_clk),
    .sg_load   (sg_load),
    .sg_data   (sg_data)
);

// File: tb/sgpio_led_shifter_bench.sv
`timescale 1ns/1ps
module sgpio_led_shifter_bench;

    localparam int H  = 4;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_port = '0;
    logic [31:0] req_msg = '0;
    logic        req_ready, req_err;
    logic [7:0]  cfg_pre = '0, cfg_post = '0;
    logic [3:0]  cfg_nports = 4'd8;
    logic [23:0] cfg_slot_map;
    logic        sg_clk, sg_load, sg_data;

    int nchk = 0, nbad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sgpio_led_shifter #(.N_PORTS(NP), .HALF_CYC(H), .MSG_SLOTS(15), .CLKCNT_W(8))
    u_sgpio_led_shifter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_msg(req_msg), .req_ready(req_ready), .req_err(req_err),
        .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_nports(cfg_nports),
        .cfg_slot_map(cfg_slot_map), .sg_clk(sg_clk), .sg_load(sg_load),
        .sg_data(sg_data)
    );

    initial begin
        for (int p = 0; p < NP; p++) cfg_slot_map[3*p +: 3] = 3'(7 - p);
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [2:0]  q[$];
    logic [2:0]  exp_o = 3'b111;
    bit          exp_rdy = 1, exp_err = 0, m_idle = 1;
    bit [23:0]   mpat = '0;

    task automatic build_frame();
        logic [1:0] sl[$];
        for (int i = 0; i < int'(cfg_pre); i++) sl.push_back(2'b01);
        sl.push_back(2'b11);
        for (int i = 0; i < 3*int'(cfg_nports); i++) sl.push_back({1'b0, mpat[i]});
        for (int i = 0; i < int'(cfg_post); i++) sl.push_back(2'b01);
        foreach (sl[k]) begin
            repeat (H) q.push_back({1'b0, sl[k]});
            repeat (H) q.push_back({1'b1, sl[k]});
        end
        repeat (H) q.push_back({1'b0, sl[sl.size()-1]});
    endtask

    always @(posedge clk) begin : mdl
        int s;
        if (!rst_n) begin
            q.delete();
            m_idle = 1; exp_o = 3'b111; exp_rdy = 1; exp_err = 0; mpat = '0;
        end else begin
            exp_err = 0;
            if (m_idle && req_valid) begin
                if (req_msg[15:8] >= 8'd15) exp_err = 1;
                else begin
                    s = int'(cfg_slot_map[3*req_port +: 3]);
                    mpat[3*s]   = req_msg[20] | req_msg[21];
                    mpat[3*s+1] = req_msg[19];
                    mpat[3*s+2] = req_msg[22];
                    build_frame();
                end
            end
            if (q.size() > 0) begin
                exp_o = q.pop_front(); m_idle = 0; exp_rdy = 0;
            end else begin
                exp_o = 3'b111; m_idle = 1; exp_rdy = 1;
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sg_clk  == exp_o[2], "R5 sg_clk",  sg_clk,  exp_o[2]);
            chk(sg_load == exp_o[1], "R4 sg_load", sg_load, exp_o[1]);
            chk(sg_data == exp_o[0], "R1 sg_data", sg_data, exp_o[0]);
            chk(req_ready == exp_rdy, "R8 req_ready", req_ready, exp_rdy);
            chk(req_err == exp_err, "R7 req_err", req_err, exp_err);
        end
    end

    // capture {load,data} at each rising link clock within a frame
    logic [1:0] cap[$];
    bit prev_clk = 1, prev_rdy = 1;
    always @(negedge clk) begin
        if (prev_rdy && !req_ready) cap.delete();
        if (sg_clk && !prev_clk && !req_ready) cap.push_back({sg_load, sg_data});
        prev_clk = sg_clk;
        prev_rdy = req_ready;
    end

    task automatic send(input int p, input logic [31:0] m);
        @(negedge clk);
        req_valid = 1; req_port = 3'(p); req_msg = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int ones_after(input int start);
        int n = 0;
        for (int i = start; i < cap.size(); i++) n += int'(cap[i][0]);
        return n;
    endfunction

    initial begin
        int busy;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(sg_clk && sg_load && sg_data, "R9 lines", {sg_clk, sg_load, sg_data}, 7);
        chk(req_ready == 1 && req_err == 0, "R9 ready/err", {req_ready, req_err}, 2);

        // port 0 -> slot 7, activity via bit 20
        send(0, 32'h0010_0000);
        wait_idle();
        chk(cap.size() == 25, "R6 zero pre/post length", cap.size(), 25);
        chk(cap[0] == 2'b11, "R4 load first", cap[0], 3);
        chk(cap[22][0] == 1, "R1 slot 7 activity", cap[22][0], 1);
        chk(ones_after(1) == 1, "R2 single bit", ones_after(1), 1);

        // port 3 -> slot 4, bits 21,19,22
        send(3, 32'h0068_0000);
        wait_idle();
        chk(cap[13][0] == 1, "R2 activity by bit 21", cap[13][0], 1);
        chk(cap[14][0] == 1, "R3 locate", cap[14][0], 1);
        chk(cap[15][0] == 1, "R3 fault", cap[15][0], 1);
        chk(cap[22][0] == 1, "R1 other slot kept", cap[22][0], 1);

        // junk-only message on port 3 clears slot 4, ignores other bits
        send(3, 32'hFF80_00FF);
        wait_idle();
        chk({cap[13][0], cap[14][0], cap[15][0]} == 3'b000, "R3 cleared",
            {cap[13][0], cap[14][0], cap[15][0]}, 0);
        chk(ones_after(1) == 1, "R10 stray bits ignored", ones_after(1), 1);

        // leading and trailing slots, 4 ports
        cfg_pre = 8'd3; cfg_post = 8'd2; cfg_nports = 4'd4;
        send(5, 32'h0040_0000);
        wait_idle();
        chk(cap.size() == 18, "R6 frame length", cap.size(), 18);
        chk(cap[0] == 2'b01 && cap[2] == 2'b01, "R4 leading idle", cap[0], 1);
        chk(cap[3] == 2'b11, "R4 load after leading", cap[3], 3);
        chk(cap[12][0] == 1 && cap[10][0] == 0, "R3 fault slot 2", cap[12], 1);
        chk(cap[16] == 2'b01 && cap[17] == 2'b01, "R6 trailing idle", cap[17], 1);

        // refused slot field
        send(1, 32'h0008_0F00);
        chk(req_err == 1 && req_ready == 1, "R7 refused", {req_err, req_ready}, 3);
        busy = 0;
        repeat (10) begin @(negedge clk); busy += int'(!req_ready); end
        chk(busy == 0, "R7 no frame after refuse", busy, 0);
        send(1, 32'h0008_0E00);
        chk(req_ready == 0 && req_err == 0, "R7 boundary accepted", {req_ready, req_err}, 0);
        wait_idle();

        // request held during a frame
        cfg_pre = 8'd0; cfg_post = 8'd0; cfg_nports = 4'd8;
        send(1, 32'h0008_0000);
        chk(req_ready == 0, "R8 busy when second request offered", req_ready, 0);
        send(2, 32'h0010_0000);
        wait_idle();
        chk(cap[20][0] == 1 && cap[16][0] == 1, "R8 queued update sent",
            {cap[20][0], cap[16][0]}, 3);

        repeat (5) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            nchk++; nbad++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule